// File: doc/BRIEF.md
# FIR Control Microsequencer

This block is the control unit for a small parallel FIR datapath. A program counter steps through a fixed 12-bit microword memory, and each word supplies the seven datapath strobes for one clock cycle. The counter does one of two things on each step. When the word's sequencing bit is clear, the counter increments. When the bit is set, the counter loads the word's 4-bit jump target. The microprogram is a constant inside the block.

After reset the counter rests at address 0 and all strobes are low. A `start` pulse begins the program. The program writes the four tap coefficients and clears the delay line. It then takes in four samples: the first with a plain load, the other three with a combined shift-and-load. A latch strobe follows each load. The last word jumps to itself and drives no strobes, so the block stays halted until the next reset.

The microword layout is as follows. Bit 11 is the sequencing bit, where 1 means jump. Bits 10:7 hold the jump target. Bits 6:0 hold the strobes: bit 6 is `coef_we`, bits 5:4 are `coef_sel`, bit 3 is `tap_clr`, bit 2 is `tap_ld`, bit 1 is `y_latch` and bit 0 is `tap_shift`. The strobe outputs are registered.

Top module: `ucode_seq`

## Requirements
- R1: While `rst_n` is low, every strobe output is 0.
- R2: After reset and before `start` is sampled high, every strobe output stays 0 on every cycle.
- R3: If `start` is high at a rising edge while the block is idle, the strobes of microword k appear after the (k+1)-th rising edge that follows that sampling edge. Each microword is presented for exactly one cycle.
- R5: Microwords 0 to 3 each assert only `coef_we`, with `coef_sel` equal to the word index (0, 1, 2, 3 in that order).
- R6: Microword 4 asserts only `tap_clr`. Microword 5 asserts only `tap_ld`. Microword 6 asserts only `y_latch`.
- R7: Microwords 7, 9 and 11 assert `tap_shift` and `tap_ld` together, and nothing else. Microwords 8, 10 and 12 assert only `y_latch`.
- R8: Microword 13 jumps to itself with all strobes 0. From then on the outputs stay 0.
- R9: `start` has no effect while the program runs or is halted. The trace continues unchanged, and a halted block stays halted.
- R10: At most one of `coef_we`, `tap_clr`, `tap_ld` and `y_latch` is high in any cycle. `coef_sel` is nonzero only while `coef_we` is high.
- R11: A reset in the middle of the program zeroes the outputs at once. After reset the block is idle again, and a new `start` replays the full trace from word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins the microprogram when sampled high while idle |
| coef_we | output | 1 | Coefficient register write enable |
| coef_sel | output | 2 | Coefficient register select |
| tap_clr | output | 1 | Clear all delay-line registers |
| tap_ld | output | 1 | Load the new sample into the first delay-line register |
| y_latch | output | 1 | Latch the filter sum into the output register |
| tap_shift | output | 1 | Shift the delay line by one position |

## Verification
The first microword reaches the outputs two rising edges after `start` is driven. The first edge sets the run flag. The second edge registers word 0. Every later word follows one edge after the one before it. A reset acts on the outputs at once, but the internal release takes two more edges, so the bench waits longer than that before it starts the program again. The bench model advances at the same rising edges as the design, from a queue filled when `start` is accepted. The outputs are compared at the falling edge, so each comparison reads values that have settled since the last edge.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  localparam int UA_W      = 4;
  localparam int UC_W      = 7;
  localparam int UW_W      = 1 + UA_W + UC_W;
  localparam int SEQ_BIT   = UW_W - 1;
  localparam int TGT_LO    = UC_W;
  localparam int HALT_ADDR = 13;

  // strobe bit positions inside the control field
  localparam int B_WE    = 6;
  localparam int B_SEL_H = 5;
  localparam int B_SEL_L = 4;
  localparam int B_CLR   = 3;
  localparam int B_LD    = 2;
  localparam int B_LAT   = 1;
  localparam int B_SH    = 0;

  function automatic logic [UW_W-1:0] mk_word(input logic jump,
                                              input logic [UA_W-1:0] tgt,
                                              input logic [UC_W-1:0] ctl);
    return {jump, tgt, ctl};
  endfunction
endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
  import ucode_pkg::*;
#(
  parameter int AW = UA_W,
  parameter int WW = UW_W
) (
  input  logic [AW-1:0] addr,
  output logic [WW-1:0] word
);
  localparam logic [AW-1:0] HALT = AW'(HALT_ADDR);

  always_comb begin
    unique case (addr)
      AW'(0):  word = mk_word(1'b0, '0, 7'b100_0000);
      AW'(1):  word = mk_word(1'b0, '0, 7'b101_0000);
      AW'(2):  word = mk_word(1'b0, '0, 7'b110_0000);
      AW'(3):  word = mk_word(1'b0, '0, 7'b111_0000);
      AW'(4):  word = mk_word(1'b0, '0, 7'b000_1000);
      AW'(5):  word = mk_word(1'b0, '0, 7'b000_0100);
      AW'(6):  word = mk_word(1'b0, '0, 7'b000_0010);
      AW'(7):  word = mk_word(1'b0, '0, 7'b000_0101);
      AW'(8):  word = mk_word(1'b0, '0, 7'b000_0010);
      AW'(9):  word = mk_word(1'b0, '0, 7'b000_0101);
      AW'(10): word = mk_word(1'b0, '0, 7'b000_0010);
      AW'(11): word = mk_word(1'b0, '0, 7'b000_0101);
      AW'(12): word = mk_word(1'b0, '0, 7'b000_0010);
      default: word = mk_word(1'b1, HALT, 7'b000_0000);
    endcase
  end
endmodule

// File: rtl/ucode_pc.sv
module ucode_pc #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         jump,
  input  logic [W-1:0] tgt,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) begin
      if (jump) q_nxt = tgt;
      else      q_nxt = q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !jump) |=> (q == $past(q) + W'(1)));  // R3
  AST_PC_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && jump) |=> (q == $past(tgt)));  // R8
endmodule

// File: rtl/ucode_ctlreg.sv
module ucode_ctlreg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic b_nxt;
    always_comb b_nxt = en ? d[i] : 1'b0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= b_nxt;
    end
  end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_pkg::*;
#(
  parameter int AW = UA_W,
  parameter int CW = UC_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       coef_we,
  output logic [1:0] coef_sel,
  output logic       tap_clr,
  output logic       tap_ld,
  output logic       y_latch,
  output logic       tap_shift
);
  localparam int WW = 1 + AW + CW;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rsync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i = rsync[1];

  logic run_q, run_nxt;
  always_comb run_nxt = run_q | start;
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) run_q <= 1'b0;
    else        run_q <= run_nxt;
  end

  logic [AW-1:0] upc;
  logic [WW-1:0] uword;
  logic [CW-1:0] ctl;

  ucode_rom #(.AW(AW), .WW(WW)) u_rom (
    .addr (upc),
    .word (uword)
  );

  ucode_pc #(.W(AW)) u_pc (
    .clk   (clk),
    .rst_n (rst_i),
    .en    (run_q),
    .jump  (uword[WW-1]),
    .tgt   (uword[WW-2 -: AW]),
    .q     (upc)
  );

  ucode_ctlreg #(.W(CW)) u_ctl (
    .clk   (clk),
    .rst_n (rst_i),
    .en    (run_q),
    .d     (uword[CW-1:0]),
    .q     (ctl)
  );

  assign coef_we   = ctl[B_WE];
  assign coef_sel  = {ctl[B_SEL_H], ctl[B_SEL_L]};
  assign tap_clr   = ctl[B_CLR];
  assign tap_ld    = ctl[B_LD];
  assign y_latch   = ctl[B_LAT];
  assign tap_shift = ctl[B_SH];

  AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_i)
    !run_q |-> (upc == '0));  // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_i)
    !run_q |=> (ctl == '0));  // R2
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_i)
    run_q |=> run_q);  // R9
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    (run_q && upc == AW'(HALT_ADDR)) |=> (upc == AW'(HALT_ADDR) && ctl == '0));  // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0({coef_we, tap_clr, tap_ld, y_latch}));  // R10
  AST_SEL_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_i)
    (coef_sel != 2'b00) |-> coef_we);  // R10
endmodule

// File: tb/tb_ucode_seq.sv
module tb_ucode_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic       coef_we, tap_clr, tap_ld, y_latch, tap_shift;
  logic [1:0] coef_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  ucode_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .coef_we(coef_we), .coef_sel(coef_sel), .tap_clr(tap_clr),
    .tap_ld(tap_ld), .y_latch(y_latch), .tap_shift(tap_shift)
  );

  function automatic logic [6:0] outs();
    return {coef_we, coef_sel, tap_clr, tap_ld, y_latch, tap_shift};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference: queue of expected strobe words
  logic [6:0] exp_q[$];
  logic [6:0] exp_v;
  bit run_m;
  int idx_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_m = 0; exp_v = '0; idx_m = -1; exp_q.delete();
    end else if (!run_m) begin
      exp_v = '0;
      if (start) begin
        run_m = 1;
        for (int s = 0; s < 4; s++) exp_q.push_back({1'b1, 2'(s), 4'b0000}); // R5
        exp_q.push_back(7'h08); exp_q.push_back(7'h04); exp_q.push_back(7'h02); // R6
        for (int s = 0; s < 3; s++) begin
          exp_q.push_back(7'h05); exp_q.push_back(7'h02);   // R7
        end
        exp_q.push_back(7'h00);   // R8
      end
    end else begin
      if (exp_q.size() > 1) exp_v = exp_q.pop_front();
      else exp_v = exp_q[0];
      if (idx_m < 13) idx_m++;
    end
  end

  function automatic string tag_of(int k, bit r);
    if (!r) return "R2";
    if (k < 0) return "R3";
    if (k < 4) return "R5";
    if (k < 7) return "R6";
    if (k < 13) return "R7";
    return "R8";
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag_of(idx_m, run_m), outs(), exp_v);
      checks++;  // R10 exclusivity of strobes
      if ((coef_we + tap_clr + tap_ld + y_latch) > 1 || (coef_sel != 0 && !coef_we)) begin
        errors++;
        $display("FAIL R10: actual %0h expected exclusive strobes", outs());
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", outs(), 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    // R3: first word lands one edge after the run flag is set
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R3", outs(), 0);
    @(negedge clk);
    chk("R3", outs(), 7'h40);
    repeat (4) @(negedge clk);
    pulse_start();  // R9 mid-run
    repeat (12) @(negedge clk);
    chk("R8", outs(), 0);
    pulse_start();  // R9 while halted
    repeat (3) @(negedge clk);
    chk("R9", outs(), 0);
    // R11: restart from scratch, then reset mid-program
    rst_n = 1'b0;
    #1 chk("R11", outs(), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    pulse_start();
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R11", outs(), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11", outs(), 0);
    pulse_start();
    repeat (20) @(negedge clk);
    chk("R11", outs(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    done = 1;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule